// File: doc/BRIEF.md
# Serial Clock Wait and Interrupt Timer

This block runs beside an 8-bit serial shift engine that works either as a three-wire clocked link or as an I2C-style two-wire link. It synchronises the serial clock pin into the system clock domain, counts its rising edges within each byte, and raises a one-cycle interrupt request at the edge chosen by a two-bit wait-mode field. In the two hold modes it then pulls the clock line low (clock stretching) until software writes a release bit or a stop condition is seen.

Software reaches the block through one byte-wide control register. The register also carries a clock-level control bit, which sets whether the clock line is pulled low or left floating while no transfer is in progress, and a read-only bit that shows the synchronised clock pin level. Start and stop detection, transfer-busy indication and the mode select come in as plain inputs from the surrounding serial engine. The clock line output is an active-high pull-low enable for an open-drain pad.

Top module: `sclk_wait_ctrl`

## Requirements
- R1: After reset, register bits 0 to 5 and 7 read 0, the interrupt output is low and no wait is held.
- R2: With wait mode 00 (bits 2:1), exactly one interrupt pulse is raised on the 8th synchronised clock rising edge of a byte, no stretching follows, and the edge count restarts so every further 8 edges raise one more pulse.
- R3: Wait mode 01 is reserved: it raises no interrupt and never holds the clock line.
- R4: Wait mode 10 raises the interrupt on the 8th rising edge and then keeps the pull-low enable asserted until the wait is ended.
- R5: Wait mode 11 raises the interrupt on the 9th rising edge (8 edges raise nothing) and then keeps the pull-low enable asserted until the wait is ended.
- R6: Writing 1 to the release bit (bit 0) ends an active wait and restarts the edge count; the bit reads back 0 again without software clearing it.
- R7: A stop condition pulse ends an active wait.
- R8: In two-wire mode with no wait held, the pull-low enable is asserted exactly when no transfer is busy and the clock-level bit (bit 3) is 0.
- R9: Bit 6 reads the synchronised clock pin level; writes to it are ignored.
- R10: In three-wire mode the clock-level bit stores 0 whatever is written and the pull-low enable is never asserted.
- R11: Every interrupt pulse lasts exactly one system clock cycle.
- R12: A start condition pulse discards the edges counted so far in the current byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| two_wire | input | 1 | 1 selects the I2C-style two-wire mode, 0 the three-wire mode |
| scl_pin | input | 1 | Serial clock pin level, asynchronous |
| start_seen | input | 1 | One-cycle start condition pulse |
| stop_seen | input | 1 | One-cycle stop condition pulse |
| xfer_busy | input | 1 | High while a byte transfer is in progress |
| irq | output | 1 | One-cycle interrupt request |
| scl_pull_low | output | 1 | Active-high enable to pull the clock line low |

## Verification
The bench walks every wait mode with edge counts one short of, equal to and beyond the interrupt point, so a design that fires one edge early or late, fires on the reserved code, or forgets to restart its count after a plain-mode byte shows the wrong number of pulses. It holds a wait and ends it once by release and once by stop; a release that did not clear itself or did not restart the count would miss the next pulse or leave the line held. Idle-level and three-wire cases catch a pull-low enable that ignores the busy, level or mode inputs, and a partial byte cut by a start condition catches a count that was not cleared.

// File: rtl/sclk_wait_pkg.sv
package sclk_wait_pkg;

    localparam int REG_W      = 8;
    localparam int CNT_W      = 4;
    localparam int BIT_REL    = 0;
    localparam int BIT_MODE   = 1;
    localparam int BIT_LVL    = 3;
    localparam int BIT_STAT   = 6;

    typedef enum logic [1:0] {
        WM_PLAIN = 2'b00,
        WM_RSVD  = 2'b01,
        WM_HOLD8 = 2'b10,
        WM_HOLD9 = 2'b11
    } wmode_e;

    typedef struct packed {
        logic   rel;
        wmode_e mode;
        logic   lvl;
    } ctrl_t;

endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    localparam int TOP = STAGES;

    logic [TOP:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_i;
    end

    for (genvar g = 1; g <= TOP; g++) begin : g_stage
        always_comb chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[TOP-1];
    assign rise_o  = chain_q[TOP-1] & ~chain_q[TOP];

    p_rise_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/sclk_edge_count.sv
module sclk_edge_count
    import sclk_wait_pkg::*;
#(
    parameter int W          = CNT_W,
    parameter int EDGE_SHORT = 8,
    parameter int EDGE_LONG  = 9
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rise_i,
    input  logic   start_i,
    input  logic   rel_done_i,
    input  wmode_e mode_i,
    input  logic   stretch_i,
    output logic   hit_o,
    output logic   irq_o
);
    localparam logic [W-1:0] SAT   = W'(EDGE_LONG);
    localparam logic [W-1:0] T_SH  = W'(EDGE_SHORT);
    localparam logic [W-1:0] T_LG  = W'(EDGE_LONG);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [W-1:0] target;
    logic [W-1:0] nxt;
    logic         legal;

    always_comb begin
        target = (mode_i == WM_HOLD9) ? T_LG : T_SH;
        legal  = (mode_i != WM_RSVD);
        nxt    = st_q.cnt + W'(1);
        hit_o  = rise_i & legal & (nxt == target) & (st_q.cnt < SAT);

        st_d     = st_q;
        st_d.irq = hit_o;
        if (start_i || rel_done_i) begin
            st_d.cnt = '0;
            st_d.irq = 1'b0;
        end else if (hit_o && !stretch_i) begin
            st_d.cnt = '0;
        end else if (rise_i && st_q.cnt < SAT) begin
            st_d.cnt = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= SAT);
    p_irq_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == WM_RSVD && $past(mode_i) == WM_RSVD) |-> !irq_o);
    p_start_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.cnt == '0 && !irq_o));

endmodule

// File: rtl/sclk_wait_hold.sv
module sclk_wait_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic stretch_i,
    input  logic rel_i,
    input  logic stop_i,
    input  logic two_wire_i,
    input  logic lvl_i,
    input  logic busy_i,
    output logic rel_done_o,
    output logic pull_o
);
    typedef struct packed {
        logic hold;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        rel_done_o = st_q.hold & rel_i;
        st_d       = st_q;
        if (stop_i || rel_done_o)        st_d.hold = 1'b0;
        else if (hit_i && stretch_i)     st_d.hold = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pull_o = two_wire_i & (st_q.hold | (~lvl_i & ~busy_i));

    p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !st_q.hold);
    p_rel_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && rel_i) |=> !st_q.hold);
    p_hold_pulls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && two_wire_i) |-> pull_o);

endmodule

// File: rtl/sclk_wait_ctrl.sv
module sclk_wait_ctrl
    import sclk_wait_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_SHORT  = 8,
    parameter int EDGE_LONG   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             two_wire,
    input  logic             scl_pin,
    input  logic             start_seen,
    input  logic             stop_seen,
    input  logic             xfer_busy,
    output logic             irq,
    output logic             scl_pull_low
);
    ctrl_t ctrl_d, ctrl_q;
    logic  scl_lvl, scl_rise, hit, rel_done, stretch;

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.rel = 1'b0;
        if (reg_wr) begin
            ctrl_d.rel  = reg_wdata[BIT_REL];
            ctrl_d.mode = wmode_e'(reg_wdata[BIT_MODE +: 2]);
            ctrl_d.lvl  = reg_wdata[BIT_LVL] & two_wire;
        end
        stretch = ctrl_q.mode[1] & two_wire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        reg_rdata                  = '0;
        reg_rdata[BIT_REL]         = ctrl_q.rel;
        reg_rdata[BIT_MODE +: 2]   = ctrl_q.mode;
        reg_rdata[BIT_LVL]         = ctrl_q.lvl;
        reg_rdata[BIT_STAT]        = scl_lvl;
    end

    sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (scl_pin),
        .level_o (scl_lvl),
        .rise_o  (scl_rise)
    );

    sclk_edge_count #(
        .W          (CNT_W),
        .EDGE_SHORT (EDGE_SHORT),
        .EDGE_LONG  (EDGE_LONG)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (scl_rise),
        .start_i    (start_seen),
        .rel_done_i (rel_done),
        .mode_i     (ctrl_q.mode),
        .stretch_i  (stretch),
        .hit_o      (hit),
        .irq_o      (irq)
    );

    sclk_wait_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .stretch_i  (stretch),
        .rel_i      (ctrl_q.rel),
        .stop_i     (stop_seen),
        .two_wire_i (two_wire),
        .lvl_i      (ctrl_q.lvl),
        .busy_i     (xfer_busy),
        .rel_done_o (rel_done),
        .pull_o     (scl_pull_low)
    );

    p_rel_selfclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.rel && !(reg_wr && reg_wdata[BIT_REL])) |=> !ctrl_q.rel);
    p_lvl_3wire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !two_wire) |=> !ctrl_q.lvl);
    p_no_pull_3wire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !two_wire |-> !scl_pull_low);

endmodule

// File: tb/sclk_wait_ctrl_test.sv
module sclk_wait_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       two_wire = 1'b1;
    logic       scl_pin = 1'b0;
    logic       start_seen = 1'b0;
    logic       stop_seen = 1'b0;
    logic       xfer_busy = 1'b0;
    logic       irq;
    logic       scl_pull_low;

    int total = 0;
    int bad = 0;
    int irq_total = 0;
    int irq_wide = 0;
    logic irq_prev = 1'b0;

    always #5 clk = ~clk;

    sclk_wait_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .two_wire(two_wire), .scl_pin(scl_pin),
        .start_seen(start_seen), .stop_seen(stop_seen), .xfer_busy(xfer_busy),
        .irq(irq), .scl_pull_low(scl_pull_low)
    );

    always @(negedge clk) begin
        if (irq) irq_total++;
        if (irq && irq_prev) irq_wide++;
        irq_prev = irq;
    end

    typedef struct packed {
        logic [1:0] mode;
        logic       tw;
        logic [7:0] npulse;
        logic [7:0] nirq;
        logic       pull;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b1, 8'd8,  8'd1, 1'b0},
        '{2'b00, 1'b1, 8'd7,  8'd0, 1'b0},
        '{2'b00, 1'b1, 8'd16, 8'd2, 1'b0},
        '{2'b01, 1'b1, 8'd9,  8'd0, 1'b0},
        '{2'b10, 1'b1, 8'd8,  8'd1, 1'b1},
        '{2'b10, 1'b1, 8'd7,  8'd0, 1'b0},
        '{2'b11, 1'b1, 8'd8,  8'd0, 1'b0},
        '{2'b11, 1'b1, 8'd9,  8'd1, 1'b1},
        '{2'b10, 1'b0, 8'd8,  8'd1, 1'b0},
        '{2'b11, 1'b0, 8'd18, 8'd2, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start_seen = 1'b1;
        @(posedge clk); #1 start_seen = 1'b0;
    endtask

    task automatic pulse_stop();
        @(posedge clk); #1 stop_seen = 1'b1;
        @(posedge clk); #1 stop_seen = 1'b0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            scl_pin = 1'b1;
            repeat (4) @(posedge clk); #1;
            scl_pin = 1'b0;
            repeat (4) @(posedge clk); #1;
        end
        repeat (4) @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl bits", int'(reg_rdata & 8'hBF), 0);
        chk("R1 irq", int'(irq), 0);
        // R8 idle pull with level bit 0, not busy
        chk("R8 idle pull lvl0", int'(scl_pull_low), 1);

        // Table walk: level bit 1 and busy so only a hold can pull
        for (int k = 0; k < NV; k++) begin
            two_wire = VEC[k].tw;
            xfer_busy = 1'b1;
            wr({4'b0, 1'b1, VEC[k].mode, 1'b0});
            pulse_start();
            base = irq_total;
            edges(int'(VEC[k].npulse));
            @(negedge clk);
            chk($sformatf("R2/R3/R4/R5 vec%0d irq count", k), irq_total - base, int'(VEC[k].nirq));
            chk($sformatf("R4/R5/R10 vec%0d pull", k), int'(scl_pull_low), int'(VEC[k].pull));
            pulse_stop();
            repeat (2) @(posedge clk); #1;
        end
        chk("R11 irq single cycle", irq_wide, 0);

        // R6 release ends wait, self-clears, count restarts
        two_wire = 1'b1; xfer_busy = 1'b1;
        wr(8'b0000_1100);
        pulse_start();
        edges(8);
        @(negedge clk);
        chk("R4 hold after 8th edge", int'(scl_pull_low), 1);
        wr(8'b0000_1101);
        repeat (3) @(posedge clk); #1;
        @(negedge clk);
        chk("R6 release bit self-clear", int'(reg_rdata[0]), 0);
        chk("R6 pull dropped after release", int'(scl_pull_low), 0);
        base = irq_total;
        edges(8);
        @(negedge clk);
        chk("R6 count restarted", irq_total - base, 1);
        chk("R6 held again", int'(scl_pull_low), 1);
        // R7 stop ends wait
        pulse_stop();
        @(negedge clk);
        chk("R7 stop ends hold", int'(scl_pull_low), 0);

        // R12 start discards partial byte
        wr(8'b0000_1000);
        pulse_start();
        base = irq_total;
        edges(5);
        pulse_start();
        edges(7);
        @(negedge clk);
        chk("R12 partial byte discarded", irq_total - base, 0);

        // R8 idle level control
        xfer_busy = 1'b0;
        wr(8'b0000_1000);
        @(negedge clk);
        chk("R8 idle lvl1 floats", int'(scl_pull_low), 0);
        wr(8'b0000_0000);
        @(negedge clk);
        chk("R8 idle lvl0 pulls", int'(scl_pull_low), 1);
        xfer_busy = 1'b1;
        @(negedge clk);
        chk("R8 busy lvl0 no pull", int'(scl_pull_low), 0);

        // R9 status bit follows pin, write ignored
        scl_pin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 status high", int'(reg_rdata[6]), 1);
        scl_pin = 1'b0;
        wr(8'h40);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 status low after write", int'(reg_rdata[6]), 0);
        chk("R9 other bits zero", int'(reg_rdata & 8'hBF), 0);

        // R10 three-wire mode: level bit stores 0, no pull
        two_wire = 1'b0; xfer_busy = 1'b0;
        wr(8'b0000_1000);
        @(negedge clk);
        chk("R10 lvl stored 0", int'(reg_rdata[3]), 0);
        chk("R10 no pull", int'(scl_pull_low), 0);
        chk("R11 irq single cycle final", irq_wide, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule